// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Region Entries

This block translates 48-bit virtual addresses into 32-bit physical addresses. It holds two kinds of mapping. The first kind is a fully associative set of ordinary entries, each covering one 4 KB page. The second kind is a small set of region entries. Each region entry covers an aligned power-of-two span of 4 KB up to 16 MB, sized by a code. Both kinds are searched in parallel on every lookup. The result comes back combinationally in the same cycle the virtual address is presented.

A lookup that finds no mapping raises a miss flag. An external refill agent reacts to it and installs the missing mapping through the insert port. Page entries are installed at a rotating victim slot. Region entries are installed at a slot named by the refill agent. A single flush input drops every mapping at once.

Top module: `fa_xlate_tlb`

## Requirements
- R1: After reset every lookup misses, with `lk_hit`=0, `lk_miss`=1 and `lk_paddr`=0.
- R2: Once a page mapping is installed (VA bits [47:12] as tag, `ins_paddr` bits [31:12] as frame), a lookup of any address in that 4 KB page hits in the same cycle. It returns {frame, VA[11:0]}. An address in a different page does not match that entry.
- R3: `lk_miss` is 1 exactly when `lk_valid` is 1 and nothing matches, and `lk_paddr` is then 0. With `lk_valid`=0 both `lk_hit` and `lk_miss` are 0.
- R4: A region entry with size code s (0..12) spans 4 KB<<s. Only VA bits at and above position 12+s are compared. The result takes its bits below 12+s from the VA and its upper bits from the stored physical base.
- R5: Size codes 13..15 are treated as code 12, a 16 MB span.
- R6: When a region entry and a page entry both match, the region translation is returned.
- R7: Page installs fill the 96 slots in rotating order and wrap around. After 96 distinct installs, the 97th evicts the oldest one and keeps the other 95.
- R8: A region install (`ins_block`=1) writes the slot given by `ins_slot` and replaces whatever that slot held.
- R9: `flush_all` removes every page and region mapping. An install in the same cycle as a flush is discarded.
- R10: An install becomes visible from the cycle after the clock edge that takes it. A lookup in the install cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_paddr | output | 32 | Translated physical address, 0 when no hit |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup matched nothing |
| ins_valid | input | 1 | Install request from the refill agent |
| ins_block | input | 1 | 1 = region entry, 0 = page entry |
| ins_slot | input | 2 | Region slot to write |
| ins_size | input | 4 | Region size code (span = 4 KB << code, capped at 12) |
| ins_vaddr | input | 48 | Virtual base of the new mapping |
| ins_paddr | input | 32 | Physical base of the new mapping |
| flush_all | input | 1 | Drop every mapping |

## Verification
Lookup results are combinational. The bench drives a lookup on the falling edge and samples `lk_hit`, `lk_miss` and `lk_paddr` one nanosecond later, in the same cycle. Installs and flushes take effect at the next rising edge. Their effect is therefore checked only on a lookup sampled after that edge. The one-cycle visibility rule is checked by sampling once before and once after the edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    KIND_PAGE  = 1'b0,
    KIND_BLOCK = 1'b1
  } entry_kind_e;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 96,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (step) ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
  end

  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && ptr == IDX_W'(N - 1)) |=> (ptr == '0));
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr));
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr <= IDX_W'(N - 1));
endmodule

// File: rtl/tlb_page_cam.sv
module tlb_page_cam #(
  parameter int VPN_W = 36,
  parameter int PPN_W = 20,
  parameter int N     = 96,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             any_hit,
  output logic [PPN_W-1:0] hit_ppn
);
  logic [N-1:0]     vld;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     hv;

  always_ff @(posedge clk) begin
    if (rst || flush) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hv[g] = vld[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) hit_ppn = ppn_q[i];
    end
  end

  assign any_hit = |hv;

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
  a_r10_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/tlb_block_set.sv
module tlb_block_set #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 32,
  parameter int PG_SH  = 12,
  parameter int BLK_SH = 24,
  parameter int N_BLK  = 4,
  parameter int SZ_W   = 4,
  parameter int SLOT_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [VA_W-1:0]   wr_va,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [VA_W-1:0]   lk_va,
  output logic              any_hit,
  output logic [PA_W-1:0]   hit_pa
);
  localparam int MAX_CODE = BLK_SH - PG_SH;

  logic [N_BLK-1:0] vld;
  logic [VA_W-1:0]  base_q [N_BLK];
  logic [PA_W-1:0]  pa_q   [N_BLK];
  logic [SZ_W-1:0]  sz_q   [N_BLK];
  logic [PA_W-1:0]  xl     [N_BLK];
  logic [N_BLK-1:0] hv;
  logic [SZ_W-1:0]  wr_size_c;

  assign wr_size_c = (wr_size > SZ_W'(MAX_CODE)) ? SZ_W'(MAX_CODE) : wr_size;

  always_ff @(posedge clk) begin
    if (rst || flush) vld <= '0;
    else if (wr_en) vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      base_q[wr_slot] <= wr_va;
      pa_q[wr_slot]   <= wr_pa;
      sz_q[wr_slot]   <= wr_size_c;
    end
  end

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    logic [VA_W-1:0] msk;
    always_comb begin
      for (int b = 0; b < VA_W; b++) msk[b] = (b < PG_SH + int'(sz_q[g]));
    end
    assign hv[g] = vld[g] && (((lk_va ^ base_q[g]) & ~msk) == '0);
    assign xl[g] = (pa_q[g] & ~msk[PA_W-1:0]) | (lk_va[PA_W-1:0] & msk[PA_W-1:0]);

    a_r5_size_capped: assert property (@(posedge clk) disable iff (rst)
      vld[g] |-> (sz_q[g] <= SZ_W'(MAX_CODE)));
  end

  always_comb begin
    hit_pa = '0;
    for (int i = N_BLK - 1; i >= 0; i--) begin
      if (hv[i]) hit_pa = xl[i];
    end
  end

  assign any_hit = |hv;

  a_r9_blk_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
  a_r8_slot_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld[$past(wr_slot)]);
endmodule

// File: rtl/fa_xlate_tlb.sv
module fa_xlate_tlb #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 32,
  parameter int PG_SH  = 12,
  parameter int N_PAGE = 96,
  parameter int N_BLK  = 4,
  parameter int BLK_SH = 24,
  parameter int SZ_W   = 4,
  localparam int SLOT_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_hit,
  output logic              lk_miss,
  input  logic              ins_valid,
  input  logic              ins_block,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [SZ_W-1:0]   ins_size,
  input  logic [VA_W-1:0]   ins_vaddr,
  input  logic [PA_W-1:0]   ins_paddr,
  input  logic              flush_all
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PG_SH;
  localparam int PPN_W = PA_W - PG_SH;
  localparam int IDX_W = (N_PAGE > 1) ? $clog2(N_PAGE) : 1;

  entry_kind_e      kind;
  logic             pg_wr, blk_wr;
  logic [IDX_W-1:0] victim;
  logic             pg_hit, blk_hit;
  logic [PPN_W-1:0] pg_ppn;
  logic [PA_W-1:0]  pg_pa, blk_pa;

  assign kind   = entry_kind_e'(ins_block);
  assign pg_wr  = ins_valid && (kind == KIND_PAGE);
  assign blk_wr = ins_valid && (kind == KIND_BLOCK);

  tlb_rr_ptr #(.N(N_PAGE), .IDX_W(IDX_W)) u_rr (
    .clk  (clk),
    .rst  (rst),
    .step (pg_wr && !flush_all),
    .ptr  (victim)
  );

  tlb_page_cam #(.VPN_W(VPN_W), .PPN_W(PPN_W), .N(N_PAGE), .IDX_W(IDX_W)) u_pages (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_all),
    .wr_en   (pg_wr),
    .wr_idx  (victim),
    .wr_vpn  (ins_vaddr[VA_W-1:PG_SH]),
    .wr_ppn  (ins_paddr[PA_W-1:PG_SH]),
    .lk_vpn  (lk_vaddr[VA_W-1:PG_SH]),
    .any_hit (pg_hit),
    .hit_ppn (pg_ppn)
  );

  tlb_block_set #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH), .BLK_SH(BLK_SH),
                  .N_BLK(N_BLK), .SZ_W(SZ_W), .SLOT_W(SLOT_W)) u_blocks (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_all),
    .wr_en   (blk_wr),
    .wr_slot (ins_slot),
    .wr_size (ins_size),
    .wr_va   (ins_vaddr),
    .wr_pa   (ins_paddr),
    .lk_va   (lk_vaddr),
    .any_hit (blk_hit),
    .hit_pa  (blk_pa)
  );

  assign pg_pa = {pg_ppn, lk_vaddr[PG_SH-1:0]};

  always_comb begin
    lk_hit   = lk_valid && (blk_hit || pg_hit);
    lk_miss  = lk_valid && !(blk_hit || pg_hit);
    lk_paddr = '0;
    if (lk_valid) begin
      if (blk_hit)     lk_paddr = blk_pa;
      else if (pg_hit) lk_paddr = pg_pa;
    end
  end

  a_r6_block_wins: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && blk_hit && pg_hit) |-> (lk_paddr == blk_pa));
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_paddr == '0 && !lk_hit));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss));
  a_r2_page_offset: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && pg_hit && !blk_hit) |-> (lk_paddr[PG_SH-1:0] == lk_vaddr[PG_SH-1:0]));
endmodule

// File: tb/fa_xlate_tlb_bench.sv
module fa_xlate_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic [31:0] lk_paddr;
  logic        lk_hit, lk_miss;
  logic        ins_valid = 1'b0;
  logic        ins_block = 1'b0;
  logic [1:0]  ins_slot = '0;
  logic [3:0]  ins_size = '0;
  logic [47:0] ins_vaddr = '0;
  logic [31:0] ins_paddr = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fa_xlate_tlb u_fa_xlate_tlb (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .ins_valid(ins_valid), .ins_block(ins_block), .ins_slot(ins_slot),
    .ins_size(ins_size), .ins_vaddr(ins_vaddr), .ins_paddr(ins_paddr),
    .flush_all(flush_all)
  );

  // vector: {vaddr[48], expect_hit[1], expect_paddr[32]}
  localparam logic [80:0] VEC [0:9] = '{
    {48'h0000_1234_5ABC, 1'b1, 32'hABCD_EABC},   // R2 page hit
    {48'h0000_1234_6ABC, 1'b0, 32'h0},           // R2 neighbour page
    {48'h7FFF_0000_3FFF, 1'b1, 32'h0004_2FFF},   // R2 page hit
    {48'hFFFF_0000_3000, 1'b0, 32'h0},           // R2 top bit differs
    {48'h0000_0100_0123, 1'b1, 32'h8000_0123},   // R6 region beats page
    {48'h0000_01AB_CDEF, 1'b1, 32'h80AB_CDEF},   // R4 16 MB region
    {48'h0000_0200_0000, 1'b0, 32'h0},           // R4 past region end
    {48'h0000_2000_FFFF, 1'b1, 32'h1234_FFFF},   // R4 64 KB region
    {48'h0000_2001_0000, 1'b0, 32'h0},           // R4 past 64 KB
    {48'h0000_00FF_FFFF, 1'b0, 32'h0}            // R3 below region
  };

  task automatic check(string tag, logic ehit, logic [31:0] epa);
    checks++;
    if (lk_hit !== ehit || lk_miss !== !ehit || lk_paddr !== epa) begin
      failures++;
      $display("FAIL %s va=%h: hit=%b miss=%b pa=%h expected hit=%b pa=%h",
               tag, lk_vaddr, lk_hit, lk_miss, lk_paddr, ehit, epa);
    end
  endtask

  task automatic look(string tag, logic [47:0] va, logic ehit, logic [31:0] epa);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    #1;
    check(tag, ehit, epa);
  endtask

  task automatic put_page(logic [47:0] va, logic [19:0] ppn);
    @(negedge clk);
    ins_valid = 1'b1; ins_block = 1'b0; ins_vaddr = va; ins_paddr = {ppn, 12'h0};
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  task automatic put_blk(logic [1:0] slot, logic [3:0] sz, logic [47:0] va, logic [31:0] pa);
    @(negedge clk);
    ins_valid = 1'b1; ins_block = 1'b1; ins_slot = slot; ins_size = sz;
    ins_vaddr = va; ins_paddr = pa;
    @(posedge clk); #1;
    ins_valid = 1'b0; ins_block = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(posedge clk); #1;
    flush_all = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: empty after reset
    look("R1", 48'h0000_1234_5ABC, 1'b0, 32'h0);
    look("R1", 48'h0000_0000_0000, 1'b0, 32'h0);

    // R3: idle lookup raises neither flag
    @(negedge clk); lk_valid = 1'b0; #1;
    checks++;
    if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
      failures++;
      $display("FAIL R3 idle: hit=%b miss=%b expected 0 0", lk_hit, lk_miss);
    end

    // setup
    put_page(48'h0000_1234_5000, 20'hABCDE);
    put_page(48'h7FFF_0000_3000, 20'h00042);
    put_page(48'h0000_0100_0000, 20'h11111);
    put_blk(2'd0, 4'd12, 48'h0000_0100_0000, 32'h8000_0000);   // R8 slot 0
    put_blk(2'd2, 4'd4,  48'h0000_2000_0000, 32'h1234_0000);   // R8 slot 2

    for (int i = 0; i < 10; i++) begin
      look("R2/R3/R4/R6 table", VEC[i][80:33], VEC[i][32], VEC[i][31:0]);
    end

    // R5: oversize code behaves as 16 MB
    put_blk(2'd1, 4'd15, 48'h0000_4000_0000, 32'h4000_0000);
    look("R5", 48'h0000_40FF_FFFF, 1'b1, 32'h40FF_FFFF);
    look("R5", 48'h0000_4100_0000, 1'b0, 32'h0);

    // R8: rewriting slot 2 replaces its mapping
    put_blk(2'd2, 4'd0, 48'h0000_2000_0000, 32'h5555_5000);
    look("R8", 48'h0000_2000_0ABC, 1'b1, 32'h5555_5ABC);
    look("R8", 48'h0000_2000_1000, 1'b0, 32'h0);

    // R10: install not seen in its own cycle, seen after the edge
    @(negedge clk);
    ins_valid = 1'b1; ins_block = 1'b0;
    ins_vaddr = 48'h0000_0ABC_D000; ins_paddr = 32'h7777_7000;
    lk_valid = 1'b1; lk_vaddr = 48'h0000_0ABC_D123;
    #1 check("R10 same cycle", 1'b0, 32'h0);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    check("R10 next cycle", 1'b1, 32'h7777_7123);

    // R9: flush empties both kinds
    do_flush();
    look("R9", 48'h0000_1234_5ABC, 1'b0, 32'h0);
    look("R9", 48'h0000_01AB_CDEF, 1'b0, 32'h0);
    look("R9", 48'h0000_40FF_FFFF, 1'b0, 32'h0);

    // R9: install together with flush is dropped
    @(negedge clk);
    flush_all = 1'b1; ins_valid = 1'b1; ins_block = 1'b0;
    ins_vaddr = 48'h0000_0033_3000; ins_paddr = 32'h3333_3000;
    @(posedge clk); #1;
    flush_all = 1'b0; ins_valid = 1'b0;
    look("R9 install with flush", 48'h0000_0033_3000, 1'b0, 32'h0);

    // R7: 96 installs fill, 97th evicts the oldest
    for (int k = 0; k < 96; k++) begin
      put_page(48'(32'(k) + 32'd256) << 12, 20'(k));
    end
    look("R7 full first", 48'h0000_0010_0456, 1'b1, 32'h0000_0456);
    look("R7 full last",  48'h0000_0015_F000, 1'b1, 32'h0005_F000);
    put_page(48'h0000_0090_0000, 20'hFEDCB);
    look("R7 evicted",    48'h0000_0010_0456, 1'b0, 32'h0);
    look("R7 kept",       48'h0000_0010_1010, 1'b1, 32'h0000_1010);
    look("R7 kept last",  48'h0000_0015_FFFF, 1'b1, 32'h0005_FFFF);
    look("R7 new",        48'h0000_0090_0ABC, 1'b1, 32'hFEDC_BABC);

    @(negedge clk); lk_valid = 1'b0;
    finish_run();
  end
endmodule